// File: doc/BRIEF.md
# ROM Byte Output Width Formatter

This block takes one byte per read and delivers it to the outside in one of three widths. The byte comes from the on-chip memory when the chip-select comparison hits. When it misses, the byte is read from an 8-bit bidirectional port that is wired to an external memory. The block drives the byte out as a full parallel byte, as a four-bit half on the low port pins, or one bit at a time on a serial pin. A data-request strobe paces the delivery.

Two static control inputs pick the width. `par_i` low selects serial delivery. `par_i` high selects parallel delivery, and `hsel_i` then picks the whole byte or the upper half. The block owns the direction of the port. The port drives only while the internal memory is selected and the block is powered up. When the port reads external data, that byte always goes out on the serial pin. A one-cycle `byte_done_o` strobe after the last request of each byte lets an outside address counter advance. Address generation and the memory array sit outside the block.

Top module: `rom_out_fmt`

## Requirements
- R1: While `pd_i` is high, and after reset, `ser_o`, `port_o` and `byte_done_o` are 0, requests are ignored, and any partly sent serial byte is abandoned. The next request after `pd_i` falls starts a new byte.
- R2: `port_oe_o` is 1 exactly when `cs_hit_i` is 1 and `pd_i` is 0.
- R3: Serial delivery is chosen when the byte starts with `par_i`=0 or `cs_hit_i`=0. The k-th request (k = 1..8) sets `ser_o` to bit k-1 of the byte, least significant bit first, and the new value appears in the clock cycle after the request.
- R4: `byte_done_o` is high for exactly the one cycle after the 8th request of a serial byte, and for the one cycle after each parallel request.
- R5: With `cs_hit_i`=1, `par_i`=1 and `hsel_i`=0, each request places `mem_data_i` on `port_o[7:0]` in the next cycle.
- R6: With `cs_hit_i`=1, `par_i`=1 and `hsel_i`=1, each request places bits 7:4 of `mem_data_i` on `port_o[3:0]`, with `port_o[7:4]`=0.
- R7: With `cs_hit_i`=0 at the start of a byte, the byte is taken from `port_i` and sent serially whatever `par_i` is, and `port_o` keeps its value.
- R8: The source byte and the mode are sampled only at the first request of a byte. Changes to `mem_data_i`, `port_i`, `par_i`, `hsel_i` or `cs_hit_i` during a serial byte do not alter its remaining bits.
- R9: In a cycle with no request, `ser_o` and `port_o` hold their values and `byte_done_o` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pd_i | input | 1 | Power-down and synchronous initialise |
| par_i | input | 1 | 1 = parallel delivery, 0 = serial |
| hsel_i | input | 1 | In parallel mode, 1 = upper half on low four pins |
| cs_hit_i | input | 1 | Chip-select match, 1 = internal memory |
| req_i | input | 1 | Data request, one request per high cycle |
| mem_data_i | input | 8 | Byte from the internal memory |
| port_i | input | 8 | Port pins read value (external memory data) |
| port_o | output | 8 | Port pins drive value |
| port_oe_o | output | 1 | Port output enable |
| ser_o | output | 1 | Serial data output |
| byte_done_o | output | 1 | One-cycle strobe after a byte completes |

## Verification
A wrong bit count shows up in two ways. `byte_done_o` fires on the wrong request, and the next byte starts from a stale shift value. Both are visible within eight requests. A bad shift register or source mux gives a wrong `ser_o` value one cycle after the request that exposes it, while a bad mode capture changes which pins move on that same cycle. A fault in power-down clearing stays hidden until the first request after `pd_i` falls, when the byte restarts at the wrong bit.

// File: rtl/rom_out_fmt_pkg.sv
package rom_out_fmt_pkg;
  typedef enum logic [1:0] {
    DLV_SERIAL = 2'd0,
    DLV_BYTE   = 2'd1,
    DLV_NIBBLE = 2'd2
  } dlv_e;

  function automatic dlv_e pick_dlv(input logic cs_hit, input logic par, input logic hsel);
    if (!cs_hit || !par) return DLV_SERIAL;
    return hsel ? DLV_NIBBLE : DLV_BYTE;
  endfunction
endpackage

// File: rtl/fmt_ser.sv
module fmt_ser #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ser_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sh_q;

  // count wraps to 0 after the last bit (DATA_W is a power of two)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      ser_o  <= 1'b0;
      done_o <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      ser_o  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (load_i) begin
        ser_o <= data_i[0];
        sh_q  <= data_i >> 1;
        cnt_q <= CNT_W'(1);
      end else if (step_i) begin
        ser_o <= sh_q[0];
        sh_q  <= sh_q >> 1;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) done_o <= 1'b1;
      end
    end
  end

  assign busy_o = (cnt_q != '0);

  p_done_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i && !clr_i) |=> ($stable(ser_o) && $stable(cnt_q)));
  p_clr_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0 && !ser_o && !done_o));
endmodule

// File: rtl/fmt_port.sv
module fmt_port #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic              par_i,
  input  logic              nib_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] port_o,
  output logic              done_o
);
  localparam int NIB_W = DATA_W / 2;

  logic [DATA_W-1:0] val;

  always_comb begin
    val = data_i;
    if (nib_i) val = {{NIB_W{1'b0}}, data_i[DATA_W-1:NIB_W]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      port_o <= '0;
      done_o <= 1'b0;
    end else if (clr_i) begin
      port_o <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= load_i && par_i;
      if (load_i) port_o <= val;
    end
  end

  p_nib_upper_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && nib_i && !clr_i) |=> (port_o[DATA_W-1:NIB_W] == '0));
  p_port_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !clr_i) |=> $stable(port_o));
  p_port_clr_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (port_o == '0 && !done_o));
endmodule

// File: rtl/rom_out_fmt.sv
module rom_out_fmt
  import rom_out_fmt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pd_i,
  input  logic              par_i,
  input  logic              hsel_i,
  input  logic              cs_hit_i,
  input  logic              req_i,
  input  logic [DATA_W-1:0] mem_data_i,
  input  logic [DATA_W-1:0] port_i,
  output logic [DATA_W-1:0] port_o,
  output logic              port_oe_o,
  output logic              ser_o,
  output logic              byte_done_o
);
  dlv_e              dlv;
  logic              busy, start, ser_load, ser_step, port_load;
  logic              ser_done, par_done;
  logic [DATA_W-1:0] src;

  assign dlv       = pick_dlv(cs_hit_i, par_i, hsel_i);
  assign src       = cs_hit_i ? mem_data_i : port_i;
  assign start     = req_i && !busy;
  assign ser_load  = start && (dlv == DLV_SERIAL);
  assign ser_step  = req_i && busy;
  assign port_load = start && cs_hit_i;

  fmt_ser #(.DATA_W(DATA_W)) u_ser (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (pd_i),
    .load_i (ser_load),
    .step_i (ser_step),
    .data_i (src),
    .ser_o  (ser_o),
    .busy_o (busy),
    .done_o (ser_done)
  );

  fmt_port #(.DATA_W(DATA_W)) u_port (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (pd_i),
    .load_i (port_load),
    .par_i  (dlv != DLV_SERIAL),
    .nib_i  (dlv == DLV_NIBBLE),
    .data_i (src),
    .port_o (port_o),
    .done_o (par_done)
  );

  assign byte_done_o = ser_done || par_done;
  assign port_oe_o   = cs_hit_i && !pd_i;

  p_done_after_req_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done_o |-> ($past(req_i) && !$past(pd_i)));
  p_ext_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_hit_i && !pd_i) |=> $stable(port_o));
  p_no_dual_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ser_done && par_done));
endmodule

// File: tb/rom_out_fmt_test.sv
module rom_out_fmt_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pd = 1'b0, par = 1'b0, hsel = 1'b0, cs = 1'b1, req = 1'b0;
  logic [7:0] mem = '0, pin = '0;
  logic [7:0] port_o;
  logic       port_oe, ser, done;

  int checks = 0, errors = 0, cyc = 0;

  // reference model state
  int         m_cnt = 0;
  logic [7:0] m_byte = '0, m_port = '0;
  logic       m_ser = 1'b0, m_done = 1'b0;

  always #4 clk = ~clk;

  rom_out_fmt uut (
    .clk_i(clk), .rst_ni(rst_n), .pd_i(pd), .par_i(par), .hsel_i(hsel),
    .cs_hit_i(cs), .req_i(req), .mem_data_i(mem), .port_i(pin),
    .port_o(port_o), .port_oe_o(port_oe), .ser_o(ser), .byte_done_o(done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    logic [7:0] s;
    if (!rst_n || pd) begin
      m_cnt = 0; m_byte = '0; m_port = '0; m_ser = 1'b0; m_done = 1'b0;
    end else begin
      m_done = 1'b0;
      if (req) begin
        if (m_cnt == 0) begin
          s = cs ? mem : pin;
          if (!cs || !par) begin
            m_byte = s; m_ser = s[0]; m_cnt = 1;
            if (cs) m_port = s;
          end else begin
            m_port = hsel ? {4'h0, s[7:4]} : s;
            m_done = 1'b1;
          end
        end else begin
          m_ser = m_byte[m_cnt];
          m_cnt = m_cnt + 1;
          if (m_cnt == 8) begin m_cnt = 0; m_done = 1'b1; end
        end
      end
    end
    #1;
    if (rst_n) begin
      chk("R3 ser_o model", ser, m_ser);
      chk("R5 port_o model", port_o, m_port);
      chk("R4 byte_done_o model", done, m_done);
      chk("R2 port_oe_o model", port_oe, cs && !pd);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected <20000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(output logic d);
    @(negedge clk) req = 1'b1;
    @(negedge clk) req = 1'b0;
    d = done;
  endtask

  // eight requests with gaps; collects serial bits and done position
  task automatic get_serial(output logic [7:0] b, output int ndone, output int last_at);
    logic d;
    ndone = 0; last_at = -1;
    for (int i = 0; i < 8; i++) begin
      pulse(d);
      b[i] = ser;
      if (d) begin ndone++; last_at = i; end
      if (i % 3 == 1) idle(2);
    end
  endtask

  initial begin
    logic [7:0] b;
    logic d;
    int nd, la;
    idle(3);
    chk("R1 reset ser_o", ser, 0);
    chk("R1 reset port_o", port_o, 0);
    chk("R1 reset done", done, 0);
    rst_n = 1'b1;
    idle(2);

    // R5 byte parallel
    cs = 1; par = 1; hsel = 0; mem = 8'hA5;
    pulse(d);
    chk("R5 byte on port", port_o, 8'hA5);
    chk("R4 done after parallel", d, 1);
    idle(1);
    chk("R9 done low when idle", done, 0);
    chk("R9 port held", port_o, 8'hA5);

    // R6 nibble
    hsel = 1; mem = 8'h3C;
    pulse(d);
    chk("R6 upper half on low pins", port_o, 8'h03);
    // back-to-back parallel requests
    hsel = 0;
    @(negedge clk) begin req = 1; mem = 8'h11; end
    @(negedge clk) begin mem = 8'h22; end
    chk("R4 done first of pair", done, 1);
    @(negedge clk) req = 0;
    chk("R4 done second of pair", done, 1);
    chk("R5 second byte", port_o, 8'h22);

    // R3 internal serial
    par = 0; mem = 8'hB2;
    get_serial(b, nd, la);
    chk("R3 serial byte lsb first", b, 8'hB2);
    chk("R4 one done per serial byte", nd, 1);
    chk("R4 done after eighth", la, 7);
    chk("R3 port shows internal byte", port_o, 8'hB2);

    // R7 external serial, par ignored
    cs = 0; par = 1; pin = 8'h6D; mem = 8'hFF;
    @(negedge clk);
    chk("R2 port released", port_oe, 0);
    get_serial(b, nd, la);
    chk("R7 external byte serial", b, 8'h6D);
    chk("R7 port_o kept", port_o, 8'hB2);
    chk("R7 done once", nd, 1);

    // R8 changes mid-byte ignored
    cs = 1; par = 0; mem = 8'h81;
    for (int i = 0; i < 3; i++) begin pulse(d); b[i] = ser; end
    mem = 8'h00; pin = 8'hFF; par = 1; hsel = 1; cs = 0;
    for (int i = 3; i < 8; i++) begin pulse(d); b[i] = ser; end
    chk("R8 byte unaffected", b, 8'h81);
    chk("R8 done at end", d, 1);

    // R1 power-down mid-byte
    cs = 1; par = 0; hsel = 0; mem = 8'hE7;
    for (int i = 0; i < 3; i++) pulse(d);
    @(negedge clk) pd = 1;
    @(negedge clk);
    chk("R1 pd ser_o", ser, 0);
    chk("R1 pd port_o", port_o, 0);
    chk("R2 pd port_oe", port_oe, 0);
    pulse(d);
    chk("R1 request ignored in pd", ser, 0);
    chk("R1 no done in pd", d, 0);
    @(negedge clk) pd = 0;
    mem = 8'h5A;
    get_serial(b, nd, la);
    chk("R1 restart after pd", b, 8'h5A);
    chk("R1 done at eighth after pd", la, 7);
    idle(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule